// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the standard mode settings of an SDRAM device and uses them to produce the column addresses of a burst. A load-mode strobe captures a 15-bit mode word. The word is the 2-bit bank address placed above the 13-bit address, so the bank address forms bits 14..13. The word is taken only when the bank address is zero. From the word the block decodes the CAS latency, the burst type and the burst length. An encoding that is reserved in any of these fields is refused and sets a sticky error flag.

A burst-start strobe carries a 9-bit starting column. From the next cycle the block emits one column per cycle for as many cycles as the burst length. The order is either sequential or interleaved, and it wraps inside the aligned block of the burst length. The final beat is flagged.

The sequencer is a two-state machine. In `ST_IDLE` no column is valid. A start moves it to `ST_RUN` through the transition *launch*. In `ST_RUN` three transitions are possible:
- *advance* stays in `ST_RUN` while beats remain.
- *restart* stays in `ST_RUN` and begins again at beat 0 when a new start arrives.
- *finish* returns to `ST_IDLE` after the final beat when no new start arrives.

Burst type and length are captured at the start, so a mode load during a burst does not change that burst.

Top module: `sdram_mode_burst`

## Requirements
- R1: After reset the latency output is 2, the error flag is 0 and no column is valid. A burst started before any load uses sequential order with length 2.
- R2: A load with bank address 00 and valid fields updates the settings, and the latency output shows the new value after the same clock edge. The fields are: addr[6:4] for latency (010 gives 2, 011 gives 3), addr[3] for type (0 sequential, 1 interleave) and addr[2:0] for length (001=2, 010=4, 011=8, 100=16).
- R3: A load with any bank address other than 00 leaves the latency, type, length and error flag unchanged.
- R4: A load with bank address 00 and a reserved latency code or a reserved length code (000, 101, 110, 111) sets the error flag. The previous settings are kept. The flag stays set until reset, and later valid loads still apply.
- R5: A start sampled at a clock edge makes the column valid from that edge for exactly BL consecutive cycles. The last flag is high only on the final one, and valid then falls unless a new start arrives.
- R6: In sequential order, beat n has the low log2(BL) bits equal to (start + n) mod BL.
- R7: In interleave order, beat n has the low log2(BL) bits equal to the start's low bits XOR n.
- R8: The column bits above the low log2(BL) bits keep their starting value for the whole burst.
- R9: A start during a burst abandons the old burst and begins the new sequence at beat 0 on the next cycle.
- R10: The type and length in force when a start is sampled govern the whole burst, even if a mode load occurs during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load-mode command strobe |
| addr | input | 13 | Address bits, low part of the mode word |
| bank | input | 2 | Bank address, bits 14..13 of the mode word |
| burst_go | input | 1 | Burst-start strobe |
| start_col | input | 9 | Starting column of the burst |
| col_out | output | 9 | Current burst column |
| col_valid | output | 1 | Column output holds a beat |
| col_last | output | 1 | Current beat is the final one |
| lat_out | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err | output | 1 | Sticky reserved-encoding flag |

## Verification
Latency and error results are due right after the edge that samples the load. The bench drives inputs 1 ns after a rising edge and reads these outputs 1 ns after the following edge. The first beat of a burst is due in the cycle after the sampling edge, and each later beat is due one cycle after the one before. The driver queues each beat's column and last flag at the sampling edge, dropping any beats left from a burst being restarted. A monitor compares one queue entry at every falling edge where valid is high. After each burst the bench checks that the queue is empty and valid is low, which catches both extra and missing beats.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

    typedef enum logic {BT_SEQ = 1'b0, BT_INTLV = 1'b1} burst_kind_e;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} burst_state_e;

    typedef struct packed {
        logic [1:0]  lat;
        burst_kind_e kind;
        logic [2:0]  len_log;
    } mode_cfg_t;

    // Latency code 010 -> 2, 011 -> 3; the rest are reserved.
    function automatic logic lat_code_ok(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

    // Length code -> log2 of burst length; 0 marks a reserved code.
    function automatic logic [2:0] len_code_log(input logic [2:0] code);
        logic [2:0] r;
        unique case (code)
            3'b001:  r = 3'd1;
            3'b010:  r = 3'd2;
            3'b011:  r = 3'd3;
            3'b100:  r = 3'd4;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mode_reg.sv
module mode_reg
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BA_W-1:0]   bank,
    output mode_cfg_t         cfg,
    output logic              err
);
    localparam int WORD_W = ADDR_W + BA_W;

    logic [WORD_W-1:0] word;
    logic              hit;
    logic [2:0]        lat_code;
    logic [2:0]        len_log;
    logic              fields_ok;

    assign word      = {bank, addr};
    assign hit       = load && (bank == '0);
    assign lat_code  = word[6:4];
    assign len_log   = len_code_log(word[2:0]);
    assign fields_ok = lat_code_ok(lat_code) && (len_log != 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{lat: 2'd2, kind: BT_SEQ, len_log: 3'd1};
            err <= 1'b0;
        end else if (hit) begin
            if (fields_ok) begin
                cfg <= '{lat: lat_code[1:0], kind: burst_kind_e'(word[3]), len_log: len_log};
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import sdram_mode_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [COL_W-1:0]  start_col,
    input  burst_kind_e       kind_in,
    input  logic [2:0]        log_in,
    output logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0]  start_q,
    output burst_kind_e       kind_q,
    output logic [2:0]        log_q,
    output logic              valid,
    output logic              last
);
    burst_state_e      state, nxt;
    logic [BEAT_W:0]   span;
    logic [BEAT_W-1:0] beat_end;
    logic              at_end;

    assign span     = (BEAT_W+1)'(1) << log_q;
    assign beat_end = span[BEAT_W-1:0] - BEAT_W'(1);
    assign at_end   = (beat == beat_end);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = go ? ST_RUN : ST_IDLE;
            ST_RUN:  nxt = go ? ST_RUN : (at_end ? ST_IDLE : ST_RUN);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            beat    <= '0;
            start_q <= '0;
            kind_q  <= BT_SEQ;
            log_q   <= 3'd1;
        end else begin
            state <= nxt;
            if (go) begin
                beat    <= '0;
                start_q <= start_col;
                kind_q  <= kind_in;
                log_q   <= log_in;
            end else if (state == ST_RUN) begin
                beat <= beat + BEAT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        valid = 1'b0;
        last  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                valid = 1'b0;
                last  = 1'b0;
            end
            ST_RUN: begin
                valid = 1'b1;
                last  = at_end;
            end
        endcase
    end

endmodule

// File: rtl/col_gen.sv
module col_gen
    import sdram_mode_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BEAT_W = 4
) (
    input  logic [COL_W-1:0]  start,
    input  logic [BEAT_W-1:0] beat,
    input  burst_kind_e       kind,
    input  logic [2:0]        len_log,
    output logic [COL_W-1:0]  col
);
    logic [COL_W:0]   span;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat_x;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] il_col;

    assign span    = (COL_W+1)'(1) << len_log;
    assign mask    = span[COL_W-1:0] - COL_W'(1);
    assign beat_x  = COL_W'(beat);
    assign seq_col = (start & ~mask) | ((start + beat_x) & mask);
    assign il_col  = start ^ (beat_x & mask);

    always_comb begin
        unique case (kind)
            BT_SEQ:   col = seq_col;
            BT_INTLV: col = il_col;
        endcase
    end

endmodule

// File: rtl/sdram_mode_burst.sv
module sdram_mode_burst
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BA_W-1:0]   bank,
    input  logic              burst_go,
    input  logic [COL_W-1:0]  start_col,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        lat_out,
    output logic              mode_err
);
    localparam int BEAT_W = MAX_LOG;

    mode_cfg_t         cfg;
    logic [BEAT_W-1:0] beat;
    logic [COL_W-1:0]  start_q;
    burst_kind_e       kind_q;
    logic [2:0]        log_q;

    mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .addr  (addr),
        .bank  (bank),
        .cfg   (cfg),
        .err   (mode_err)
    );

    burst_fsm #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (burst_go),
        .start_col (start_col),
        .kind_in   (cfg.kind),
        .log_in    (cfg.len_log),
        .beat      (beat),
        .start_q   (start_q),
        .kind_q    (kind_q),
        .log_q     (log_q),
        .valid     (col_valid),
        .last      (col_last)
    );

    col_gen #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_col (
        .start   (start_q),
        .beat    (beat),
        .kind    (kind_q),
        .len_log (log_q),
        .col     (col_out)
    );

    assign lat_out = cfg.lat;

endmodule

// File: rtl/sdram_mode_burst_chk.sv
module sdram_mode_burst_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_load,
    input logic [12:0] addr,
    input logic [1:0]  bank,
    input logic        burst_go,
    input logic [8:0]  start_col,
    input logic [8:0]  col_out,
    input logic        col_valid,
    input logic        col_last,
    input logic [1:0]  lat_out,
    input logic        mode_err
);
    // R5
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R5
    go_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (col_valid && col_out == $past(start_col) || col_valid));

    // R5
    ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !burst_go) |=> !col_valid);

    // R8
    upper_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !burst_go) |=> (col_valid && col_out[8:4] == $past(col_out[8:4])));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    // R3
    other_bank_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && bank != 2'b00) |=> ($stable(lat_out) && $stable(mode_err)));

    // R2
    latency_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && bank == 2'b00 && addr[6:5] == 2'b01 && addr[2:0] != 3'b000 && addr[2] == 1'b0)
        |=> (lat_out == $past(addr[5:4])));

endmodule

bind sdram_mode_burst sdram_mode_burst_chk u_chk (.*);

// File: tb/sim_sdram_mode_burst.sv
module sim_sdram_mode_burst;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [12:0] addr = '0;
    logic [1:0]  bank = '0;
    logic        burst_go = 1'b0;
    logic [8:0]  start_col = '0;
    logic [8:0]  col_out;
    logic        col_valid;
    logic        col_last;
    logic [1:0]  lat_out;
    logic        mode_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the mode settings
    int  m_lat = 2;
    bit  m_il = 0;
    int  m_log = 1;
    bit  m_err = 0;

    logic [9:0] exp_q[$];   // {last, col}

    always #2 clk = ~clk;

    sdram_mode_burst u0 (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .addr(addr), .bank(bank),
        .burst_go(burst_go), .start_col(start_col), .col_out(col_out),
        .col_valid(col_valid), .col_last(col_last), .lat_out(lat_out), .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_col(input logic [8:0] s, input int n, input int lg, input bit il);
        logic [8:0] mask;
        mask = 9'((1 << lg) - 1);
        if (il) return s ^ (9'(n) & mask);
        return (s & ~mask) | ((s + 9'(n)) & mask);
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && col_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected beat", 1, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check("R6/R7/R8 column", int'(col_out), int'(e[8:0]));
                check("R5 last flag", int'(col_last), int'(e[9]));
            end
        end
    end

    task automatic load(input logic [1:0] b, input logic [12:0] a, input string req);
        @(posedge clk); #1;
        mode_load = 1'b1; bank = b; addr = a;
        @(posedge clk); #1;
        mode_load = 1'b0;
        if (b == 2'b00) begin
            if ((a[6:4] == 3'b010 || a[6:4] == 3'b011) && a[2:0] >= 3'd1 && a[2:0] <= 3'd4) begin
                m_lat = int'(a[5:4]);
                m_il  = a[3];
                m_log = int'(a[2:0]);
            end else begin
                m_err = 1'b1;
            end
        end
        check({req, " latency"}, int'(lat_out), m_lat);
        check({req, " error flag"}, int'(mode_err), int'(m_err));
    endtask

    task automatic go(input logic [8:0] s);
        int bl;
        @(posedge clk); #1;
        burst_go = 1'b1; start_col = s;
        @(posedge clk);
        exp_q.delete();
        bl = 1 << m_log;
        for (int n = 0; n < bl; n++) begin
            exp_q.push_back({(n == bl - 1) ? 1'b1 : 1'b0, exp_col(s, n, m_log, m_il)});
        end
        #1;
        burst_go = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (20) @(posedge clk);
        #1;
        check({req, " all beats seen"}, exp_q.size(), 0);
        check({req, " valid low after burst"}, int'(col_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset latency", int'(lat_out), 2);
        check("R1 reset error", int'(mode_err), 0);
        check("R1 reset valid", int'(col_valid), 0);
        rst_n = 1'b1;
        check("R1 idle valid", int'(col_valid), 0);

        go(9'h1A5);                 drain("R1 default BL2 seq");
        load(2'b00, 13'h032, "R2 CL3 seq BL4");
        go(9'h0F6);                 drain("R6 seq BL4");
        load(2'b00, 13'h02B, "R2 CL2 intlv BL8");
        go(9'h13D);                 drain("R7 intlv BL8");
        load(2'b01, 13'h034, "R3 other bank");
        load(2'b11, 13'h07F, "R3 other bank reserved");
        go(9'h062);                 drain("R3 mode kept");
        load(2'b00, 13'h07B, "R4 reserved latency");
        go(9'h0C1);                 drain("R4 mode kept");
        load(2'b00, 13'h035, "R4 reserved length");
        load(2'b00, 13'h037, "R4 reserved length 111");
        load(2'b00, 13'h034, "R4 sticky after valid load CL3 seq BL16");
        go(9'h1F3);                 drain("R8 seq BL16");
        load(2'b00, 13'h03C, "R2 CL3 intlv BL16");
        go(9'h0A9);                 drain("R8 intlv BL16");
        load(2'b00, 13'h032, "R2 CL3 seq BL4 again");
        go(9'h010);
        go(9'h107);                 drain("R9 restart");

        // R10: mode changes during a burst leave that burst intact
        go(9'h055);
        mode_load = 1'b1; bank = 2'b00; addr = 13'h021;
        @(posedge clk); #1;
        mode_load = 1'b0;
        m_lat = 2; m_il = 0; m_log = 1;
        check("R10 latency updated mid-burst", int'(lat_out), 2);
        drain("R10 captured length");
        go(9'h0E8);                 drain("R10 new length BL2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule